// File: doc/BRIEF.md
# Sensor Frame Capture Controller

The block takes the parallel pixel stream of an image sensor, already split into red, green and blue components alongside frame-valid and line-valid strobes, and stores one frame as grayscale into an internal buffer. All logic runs on the pixel clock. A single-cycle start pulse arms the controller. It then waits until it has seen frame-valid low, so that it never joins a frame part-way through, and captures the whole of the next frame.

Each accepted pixel is turned into luma with fixed-point weights before it is written. Pixels are written in arrival order from address zero. A downstream consumer reads any stored pixel by column and row through an independent registered read port. A ready output is low for as long as a capture is in progress.

Top module: `frame_capture`

## Requirements
- R1: After reset, ready_o is high and every coordinate reads back 0.
- R2: A start_i pulse while idle arms the controller. Capture starts only on a rising edge of frame_vld_i that follows a cycle in which the armed controller saw frame_vld_i low, so a frame that is already in progress when start_i arrives is skipped entirely.
- R3: ready_o goes low in the cycle after the first frame_vld_i high cycle of the synchronised frame. It stays low while frame_vld_i is high and returns high in the cycle after frame_vld_i is first seen low.
- R4: During capture, a pixel is accepted only in cycles where frame_vld_i and line_vld_i are both high. Accepted pixels go to consecutive buffer addresses starting at 0. Buffer address y*IMG_W+x holds pixel (x, y).
- R5: The stored value is ((77*R + 150*G + 29*B) >> 8) reduced to its GRAY_W most significant bits. With 12-bit inputs and 8-bit gray this is (77*R + 150*G + 29*B) >> 12.
- R6: A start_i pulse while armed or capturing has no effect: no extra frame is captured afterwards.
- R7: Pixels beyond IMG_W*IMG_H in one frame are dropped and leave the buffer unchanged.
- R8: rd_data_o shows the stored value at (rd_x_i, rd_y_i) one cycle after the coordinates are presented. It reads 0 when rd_x_i >= IMG_W or rd_y_i >= IMG_H.
- R9: Frames that arrive after a capture has finished, with no new start_i, do not change the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle capture request |
| frame_vld_i | input | 1 | Frame-valid strobe from the sensor |
| line_vld_i | input | 1 | Line-valid strobe from the sensor |
| red_i | input | PIX_W | Red component |
| grn_i | input | PIX_W | Green component |
| blu_i | input | PIX_W | Blue component |
| rd_x_i | input | X_W | Read column |
| rd_y_i | input | Y_W | Read row |
| rd_data_o | output | GRAY_W | Gray value at the read coordinate |
| ready_o | output | 1 | High when no capture is in progress |

## Verification
The bench issues start in the middle of a running frame. A controller that synchronised at once would store the tail of that frame at address 0 instead of the next frame. Start pulses also arrive during capture and while armed, followed by a frame with no start. A design that re-armed on them would overwrite the buffer with that later frame.

An oversized frame checks that extra pixels do not wrap around onto the first rows. Component values differ between line-valid-low cycles and valid cycles, so a write that ignored line-valid would leave the valid pixels shifted. Full-scale components reveal any loss in the weighted sum. Rows past the buffer height must read zero rather than alias into stored rows.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SYNC,
    ST_CAPT
  } cap_state_e;
endpackage

// File: rtl/fcap_luma.sv
module fcap_luma #(
  parameter int PIX_W  = 12,
  parameter int GRAY_W = 8
) (
  input  logic [PIX_W-1:0]  red_i,
  input  logic [PIX_W-1:0]  grn_i,
  input  logic [PIX_W-1:0]  blu_i,
  output logic [GRAY_W-1:0] gray_o
);
  // weights sum to 256, so the top PIX_W bits of sum are the luma
  localparam int SUM_W = PIX_W + 8;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(red_i) * SUM_W'(77)
        + SUM_W'(grn_i) * SUM_W'(150)
        + SUM_W'(blu_i) * SUM_W'(29);
  end

  assign gray_o = sum[SUM_W-1 -: GRAY_W];

  initial assert (GRAY_W <= PIX_W) else $error("GRAY_W wider than PIX_W");
endmodule

// File: rtl/fcap_ctrl.sv
module fcap_ctrl
  import fcap_pkg::*;
#(
  parameter int NUM_PIX = 192,
  parameter int ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              frame_vld_i,
  input  logic              line_vld_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              ready_o
);
  cap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)      state_d = ST_ARMED;
      ST_ARMED: if (!frame_vld_i) state_d = ST_SYNC;
      ST_SYNC:  if (frame_vld_i)  state_d = ST_CAPT;
      ST_CAPT:  if (!frame_vld_i) state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  logic in_frame;
  assign in_frame = (state_q == ST_SYNC) || (state_q == ST_CAPT);
  assign wr_en_o  = in_frame && frame_vld_i && line_vld_i
                    && (wr_addr_o < ADDR_W'(NUM_PIX));
  assign ready_o  = (state_q != ST_CAPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wr_addr_o <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ARMED && !frame_vld_i) wr_addr_o <= '0;
      else if (wr_en_o)                        wr_addr_o <= wr_addr_o + 1'b1;
    end
  end

  assert_wr_strobes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (frame_vld_i && line_vld_i));

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_o && state_q != ST_ARMED) |=> $stable(wr_addr_o));

  assert_skip_running_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && frame_vld_i) |=> (ready_o && state_q == ST_ARMED));

  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && frame_vld_i) |=> !ready_o);

  assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !frame_vld_i) |=> ready_o);
endmodule

// File: rtl/fcap_mem.sv
module fcap_mem #(
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 12,
  parameter int GRAY_W = 8,
  parameter int ADDR_W = 8,
  parameter int X_W    = 4,
  parameter int Y_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [GRAY_W-1:0] wdata_i,
  input  logic [X_W-1:0]    rd_x_i,
  input  logic [Y_W-1:0]    rd_y_i,
  output logic [GRAY_W-1:0] rd_data_o
);
  localparam int NUM_PIX = IMG_W * IMG_H;
  localparam int IDX_W   = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1;

  logic [GRAY_W-1:0] mem_q [NUM_PIX];
  logic              in_range;
  logic [ADDR_W-1:0] raddr;

  assign in_range = (32'(rd_x_i) < IMG_W) && (32'(rd_y_i) < IMG_H);
  assign raddr    = ADDR_W'(rd_y_i) * ADDR_W'(IMG_W) + ADDR_W'(rd_x_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PIX; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i[IDX_W-1:0]] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_data_o <= '0;
    else if (in_range) rd_data_o <= mem_q[raddr[IDX_W-1:0]];
    else               rd_data_o <= '0;
  end

  assert_wr_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < NUM_PIX));

  assert_oor_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |=> (rd_data_o == '0));
endmodule

// File: rtl/frame_capture.sv
module frame_capture #(
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 12,
  parameter int PIX_W  = 12,
  parameter int GRAY_W = 8,
  localparam int X_W   = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int Y_W   = (IMG_H > 1) ? $clog2(IMG_H + 1) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              frame_vld_i,
  input  logic              line_vld_i,
  input  logic [PIX_W-1:0]  red_i,
  input  logic [PIX_W-1:0]  grn_i,
  input  logic [PIX_W-1:0]  blu_i,
  input  logic [X_W-1:0]    rd_x_i,
  input  logic [Y_W-1:0]    rd_y_i,
  output logic [GRAY_W-1:0] rd_data_o,
  output logic              ready_o
);
  localparam int NUM_PIX = IMG_W * IMG_H;
  localparam int ADDR_W  = $clog2(NUM_PIX + 1);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [GRAY_W-1:0] gray;

  fcap_ctrl #(.NUM_PIX(NUM_PIX), .ADDR_W(ADDR_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .frame_vld_i(frame_vld_i),
    .line_vld_i (line_vld_i),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .ready_o    (ready_o)
  );

  fcap_luma #(.PIX_W(PIX_W), .GRAY_W(GRAY_W)) i_luma (
    .red_i (red_i),
    .grn_i (grn_i),
    .blu_i (blu_i),
    .gray_o(gray)
  );

  fcap_mem #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .GRAY_W(GRAY_W),
    .ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W)
  ) i_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en),
    .waddr_i  (wr_addr),
    .wdata_i  (gray),
    .rd_x_i   (rd_x_i),
    .rd_y_i   (rd_y_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: tb/test_frame_capture.sv
`timescale 1ns/1ps
module test_frame_capture;
  localparam int W = 16;
  localparam int H = 12;
  localparam int NPIX = W * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, fv = 1'b0, lv = 1'b0;
  logic [11:0] r = '0, g = '0, b = '0;
  logic [3:0]  rx = '0;
  logic [3:0]  ry = '0;
  logic [7:0]  rdata;
  logic        ready;

  always #5 clk = ~clk;

  frame_capture i_frame_capture (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frame_vld_i(fv),
    .line_vld_i(lv), .red_i(r), .grn_i(g), .blu_i(b),
    .rd_x_i(rx), .rd_y_i(ry), .rd_data_o(rdata), .ready_o(ready)
  );

  int    vectors = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model
  int m_state = 0;          // 0 idle, 1 armed, 2 waiting for frame edge, 3 capturing
  int m_addr = 0;
  int m_mem [NPIX];

  function automatic int luma(int rr, int gg, int bb);
    return (77 * rr + 150 * gg + 29 * bb) / 4096;
  endfunction

  task automatic check(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    int exp_rd;
    exp_rd = (int'(rx) < W && int'(ry) < H) ? m_mem[int'(ry) * W + int'(rx)] : 0;
    if ((m_state == 2 || m_state == 3) && fv && lv && m_addr < NPIX) begin
      m_mem[m_addr] = luma(int'(r), int'(g), int'(b));
      m_addr++;
    end
    case (m_state)
      0: if (start) m_state = 1;
      1: if (!fv) begin m_state = 2; m_addr = 0; end
      2: if (fv) m_state = 3;
      default: if (!fv) m_state = 0;
    endcase
    @(posedge clk);
    #1;
    check("ready", int'(ready), (m_state == 3) ? 0 : 1);
    check("rd_data", (^rdata === 1'bx) ? -1 : int'(rdata), exp_rd);
    start = 1'b0;
  endtask

  task automatic set_pix(int mode);
    case (mode)
      1: begin r = 12'hfff; g = 12'hfff; b = 12'hfff; end
      2: begin r = 12'h000; g = 12'h000; b = 12'h000; end
      default: begin
        r = 12'($urandom_range(0, 4095));
        g = 12'($urandom_range(0, 4095));
        b = 12'($urandom_range(0, 4095));
      end
    endcase
  endtask

  // frame with porches and line blanking; start pulse at cycle index st (-1 none)
  task automatic send_frame(int lines, int cols, int mode, int st);
    int k = 0;
    fv = 1'b1;
    for (int p = 0; p < 2; p++) begin
      lv = 1'b0; set_pix(0); start = (k == st); k++; tick();
    end
    for (int l = 0; l < lines; l++) begin
      for (int c = 0; c < cols; c++) begin
        lv = 1'b1; set_pix(mode); start = (k == st); k++; tick();
      end
      for (int z = 0; z < 3; z++) begin
        lv = 1'b0; set_pix(0); start = (k == st); k++; tick();
      end
    end
    fv = 1'b0;
    lv = 1'b0;
    for (int z = 0; z < 4; z++) begin
      set_pix(0); start = (k == st); k++; tick();
    end
  endtask

  task automatic sweep();
    for (int y = 0; y < H + 2; y++)
      for (int x = 0; x < W; x++) begin
        rx = 4'(x); ry = 4'(y); tick();
      end
    rx = '0; ry = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPIX; i++) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    check("ready at reset", int'(ready), 1);
    check("rd_data at reset", int'(rdata), 0);
    rst_n = 1'b1;
    sweep();

    // R2: start lands inside a running frame; that frame is skipped
    cur_req = "R2";
    send_frame(H, W, 0, 40);
    cur_req = "R3";
    send_frame(H, W, 0, -1);
    cur_req = "R4";
    sweep();

    // R6: start while armed and during capture; R9: later frame without start
    cur_req = "R6";
    start = 1'b1; tick();
    start = 1'b1; tick();
    idle(2);
    send_frame(H, W, 0, 60);
    cur_req = "R9";
    send_frame(H, W, 0, -1);
    sweep();

    // R5: full-scale and zero components
    cur_req = "R5";
    start = 1'b1; tick(); idle(2);
    send_frame(H, W, 1, -1);
    sweep();
    start = 1'b1; tick(); idle(2);
    send_frame(6, W, 2, -1);
    sweep();

    // R4: short lines pack consecutively
    cur_req = "R4";
    start = 1'b1; tick(); idle(2);
    send_frame(H, 10, 0, -1);
    sweep();

    // R7: oversized frame
    cur_req = "R7";
    start = 1'b1; tick(); idle(2);
    send_frame(H + 3, W, 0, -1);
    cur_req = "R8";
    sweep();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule